// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Serializer

This block is a parallel-in, serial-out shift register used to widen the inputs of a controller. It captures a word of parallel inputs and then sends it out one bit at a time on a serial line. A shift is triggered by an external shift clock and a second, interchangeable clock-gate line. The two lines are OR-combined, so a rising edge on either one shifts the register while the other line is low. A level-sensitive, active-low mode line controls loading. While it is low, the register follows the parallel inputs, and this takes priority over all clock activity.

The block runs on a fast system clock. The external shift clock, clock-gate and mode lines pass through a multi-flop synchronizer. A shift is detected as a low-to-high change of their synchronized OR. Each shift moves the contents one stage toward the last stage. The serial input enters stage 0, and the last stage drives the true serial output. A registered complementary output is also provided. Several instances can be chained by feeding each serial output into the next instance's serial input. One serial stream then reads all of their parallel inputs.

Top module: `gclk_piso`

## Requirements
- R1: While `shift_nload_i` is low, every stage takes its `par_i` bit (`par_i[k]` goes to stage k), whatever the levels of `sclk_i`, `sgate_i` and `ser_i`.
- R2: With `shift_nload_i` high and `sgate_i` low, a low-to-high change of `sclk_i` shifts the register by one stage.
- R3: With `shift_nload_i` high and `sclk_i` low, a low-to-high change of `sgate_i` shifts the register by one stage.
- R4: With `shift_nload_i` high and either `sclk_i` or `sgate_i` held high, toggling the other line leaves the contents unchanged.
- R5: On a shift, `ser_i` enters stage 0 and stage k moves to stage k+1. `ser_o` is stage STAGES-1, so `par_i[STAGES-1]` is the first bit to appear and `par_i[0]` the last.
- R6: `ser_n_o` is always the complement of `ser_o`.
- R7: A gated-clock rise is ignored while the mode line is low, and also when the rise reaches the synchronizer outputs in the same cycle as the mode line's rise. A shift needs the synchronized mode line to have been high for at least one cycle before the edge.
- R8: A synchronous active-high `rst` clears every stage, giving `ser_o` = 0 and `ser_n_o` = 1. Clock levels already present when reset is released cause no shift.
- R9: Two instances chained serial-out to serial-in shift out all 2×STAGES bits in order: first the downstream word from its last stage, then the upstream word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | External shift clock (asynchronous) |
| sgate_i | input | 1 | Clock-gate line, interchangeable with sclk_i (asynchronous) |
| shift_nload_i | input | 1 | High: shift mode; low: parallel load (asynchronous) |
| par_i | input | STAGES | Parallel data, bit k to stage k |
| ser_i | input | 1 | Serial input into stage 0 |
| ser_o | output | 1 | Last stage, true |
| ser_n_o | output | 1 | Last stage, complemented |

## Verification
The bench builds two instances with the default STAGES = 8 and SYNC_STAGES = 2, chained into a 16-bit serial stream. Random pin activity then crosses the stage boundary between the instances. It also exercises both shift-clock inputs, hold windows under either held-high line, loading while clocks toggle, and a mode rise that coincides with a clock rise. The two-flop default keeps the pin-to-output delay at three system cycles, so each pin change can be checked within a short fixed window.

// File: rtl/gclk_piso_pkg.sv
package gclk_piso_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } op_e;

  // bit positions inside the synchronized pin vector
  localparam int unsigned PIN_CLK = 0;
  localparam int unsigned PIN_GATE = 1;
  localparam int unsigned PIN_MODE = 2;
  localparam int unsigned PIN_W = 3;
endpackage

// File: rtl/gclk_piso_sync.sv
module gclk_piso_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [DEPTH-1:0][W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= {DEPTH{RST_VAL}};
    end else begin
      chain_q[0] <= d_i;
      for (int k = 1; k < DEPTH; k++) begin
        chain_q[k] <= chain_q[k-1];
      end
    end
  end

  assign q_o = chain_q[DEPTH-1];
endmodule

// File: rtl/gclk_piso_ctrl.sv
module gclk_piso_ctrl
  import gclk_piso_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sclk_s_i,
  input  logic sgate_s_i,
  input  logic mode_s_i,
  output op_e  op_o
);
  logic gate_now;
  logic gate_q;
  logic mode_q;
  logic gate_rise;

  assign gate_now  = sclk_s_i | sgate_s_i;
  assign gate_rise = gate_now & ~gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b1;
      mode_q <= 1'b1;
    end else begin
      gate_q <= gate_now;
      mode_q <= mode_s_i;
    end
  end

  always_comb begin
    if (!mode_s_i) begin
      op_o = OP_LOAD;
    end else if (gate_rise && mode_q) begin
      op_o = OP_SHIFT;
    end else begin
      op_o = OP_HOLD;
    end
  end

  // R7
  shift_needs_settled_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (op_o == OP_SHIFT) |-> (mode_s_i && $past(mode_s_i)));

  // R4
  no_shift_under_high_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $past(sclk_s_i | sgate_s_i) |-> (op_o != OP_SHIFT));

  // R1
  load_when_mode_low_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_s_i |-> (op_o == OP_LOAD));
endmodule

// File: rtl/gclk_piso_shreg.sv
module gclk_piso_shreg
  import gclk_piso_pkg::*;
#(
  parameter int unsigned STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  op_e               op_i,
  input  logic [STAGES-1:0] par_i,
  input  logic              ser_i,
  output logic              ser_o,
  output logic              ser_n_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;
  logic              inv_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_cell
      logic shift_src;
      if (g == 0) begin : g_head
        assign shift_src = ser_i;
      end else begin : g_body
        assign shift_src = stage_q[g-1];
      end
      assign stage_d[g] = (op_i == OP_LOAD)  ? par_i[g] :
                          (op_i == OP_SHIFT) ? shift_src : stage_q[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      inv_q   <= 1'b1;
    end else begin
      stage_q <= stage_d;
      inv_q   <= ~stage_d[LAST];
    end
  end

  assign ser_o   = stage_q[LAST];
  assign ser_n_o = inv_q;

  // R1
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_LOAD) |=> (stage_q == $past(par_i)));

  // R5
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SHIFT) |=> (stage_q == {$past(stage_q[STAGES-2:0]), $past(ser_i)}));

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_HOLD) |=> $stable(stage_q));

  // R6
  complement_chk: assert property (@(posedge clk) disable iff (rst)
    ser_n_o != ser_o);

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (stage_q == '0 && ser_n_o));
endmodule

// File: rtl/gclk_piso.sv
module gclk_piso
  import gclk_piso_pkg::*;
#(
  parameter int unsigned STAGES = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              sgate_i,
  input  logic              shift_nload_i,
  input  logic [STAGES-1:0] par_i,
  input  logic              ser_i,
  output logic              ser_o,
  output logic              ser_n_o
);
  logic [PIN_W-1:0] pins_raw;
  logic [PIN_W-1:0] pins_s;
  op_e              op;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_CLK]  = sclk_i;
    pins_raw[PIN_GATE] = sgate_i;
    pins_raw[PIN_MODE] = shift_nload_i;
  end

  gclk_piso_sync #(
    .W(PIN_W),
    .DEPTH(SYNC_STAGES),
    .RST_VAL('1)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d_i(pins_raw),
    .q_o(pins_s)
  );

  gclk_piso_ctrl u_ctrl (
    .clk(clk),
    .rst(rst),
    .sclk_s_i(pins_s[PIN_CLK]),
    .sgate_s_i(pins_s[PIN_GATE]),
    .mode_s_i(pins_s[PIN_MODE]),
    .op_o(op)
  );

  gclk_piso_shreg #(
    .STAGES(STAGES)
  ) u_shreg (
    .clk(clk),
    .rst(rst),
    .op_i(op),
    .par_i(par_i),
    .ser_i(ser_i),
    .ser_o(ser_o),
    .ser_n_o(ser_n_o)
  );
endmodule

// File: tb/gclk_piso_bench.sv
`timescale 1ns/1ps
module gclk_piso_bench;
  localparam int unsigned STAGES = 8;
  localparam int unsigned CHAIN = 2 * STAGES;
  localparam int unsigned SETTLE = 4;
  localparam int unsigned WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic p_clk = 1'b1;
  logic p_gate = 1'b0;
  logic p_mode = 1'b1;
  logic p_ser = 1'b0;
  logic [STAGES-1:0] par_a = '0;
  logic [STAGES-1:0] par_b = '0;
  logic main_ser, main_ser_n, tail_ser, tail_ser_n;

  logic [CHAIN-1:0] model = '0;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gclk_piso #(.STAGES(STAGES)) u_gclk_piso (
    .clk(clk), .rst(rst), .sclk_i(p_clk), .sgate_i(p_gate),
    .shift_nload_i(p_mode), .par_i(par_a), .ser_i(tail_ser),
    .ser_o(main_ser), .ser_n_o(main_ser_n)
  );

  gclk_piso #(.STAGES(STAGES)) u_gclk_piso_tail (
    .clk(clk), .rst(rst), .sclk_i(p_clk), .sgate_i(p_gate),
    .shift_nload_i(p_mode), .par_i(par_b), .ser_i(p_ser),
    .ser_o(tail_ser), .ser_n_o(tail_ser_n)
  );

  function automatic logic [CHAIN-1:0] next_model(
    input logic [CHAIN-1:0] cur, input logic old_g, input logic old_m,
    input logic new_g, input logic new_m, input logic d,
    input logic [STAGES-1:0] pa, input logic [STAGES-1:0] pb);
    if (!new_m) return {pa, pb};
    if (old_m && !old_g && new_g) return {cur[CHAIN-2:0], d};
    return cur;
  endfunction

  task automatic check(input string tag);
    tests++;
    if (main_ser !== model[CHAIN-1] || main_ser_n !== ~model[CHAIN-1] ||
        tail_ser !== model[STAGES-1] || tail_ser_n !== ~model[STAGES-1]) begin
      fails++;
      $display("FAIL %s: ser_o=%b ser_n_o=%b tail=%b/%b expected %b %b tail=%b/%b",
               tag, main_ser, main_ser_n, tail_ser, tail_ser_n,
               model[CHAIN-1], ~model[CHAIN-1], model[STAGES-1], ~model[STAGES-1]);
    end
  endtask

  task automatic apply(input logic c, input logic g, input logic m, input logic d,
                       input string tag);
    logic old_g, old_m;
    old_g = p_clk | p_gate;
    old_m = p_mode;
    @(negedge clk);
    p_clk = c; p_gate = g; p_mode = m; p_ser = d;
    model = next_model(model, old_g, old_m, c | g, m, d, par_a, par_b);
    repeat (SETTLE) @(negedge clk);
    check(tag);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed_0165));
    // R8: reset with the shift clock already high at release
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (SETTLE) @(negedge clk);
    check("R8 reset state");
    apply(1'b1, 1'b0, 1'b1, 1'b1, "R8 no shift from level at release");
    apply(1'b0, 1'b0, 1'b1, 1'b0, "R8 clock low after release");

    // R1: load with clocks toggling, parallel word changed mid-load
    par_a = 8'hA5; par_b = 8'h3C;
    apply(1'b0, 1'b0, 1'b0, 1'b0, "R1 load entry");
    apply(1'b1, 1'b0, 1'b0, 1'b1, "R1 clock rise during load");
    apply(1'b1, 1'b1, 1'b0, 1'b0, "R1 gate rise during load");
    par_a = 8'h96; par_b = 8'h0F;
    apply(1'b0, 1'b0, 1'b0, 1'b1, "R1 new word during load");
    // R7: mode rise together with a clock rise must not shift
    apply(1'b1, 1'b0, 1'b1, 1'b1, "R7 coincident mode and clock rise");
    apply(1'b0, 1'b0, 1'b1, 1'b0, "R7 clock low");

    // R9 / R5 / R2: read out all 16 bits through the chain with the clock pin
    for (int k = 0; k < CHAIN; k++) begin
      apply(1'b1, 1'b0, 1'b1, 1'($urandom % 2), "R9 R2 cascade shift");
      apply(1'b0, 1'b0, 1'b1, p_ser, "R5 clock fall");
    end

    // R3: shift with the gate pin while the clock pin is low
    par_a = 8'h81; par_b = 8'h7E;
    apply(1'b0, 1'b0, 1'b0, 1'b0, "R1 reload");
    apply(1'b0, 1'b0, 1'b1, 1'b0, "R1 leave load");
    for (int k = 0; k < 5; k++) begin
      apply(1'b0, 1'b1, 1'b1, 1'($urandom % 2), "R3 gate shift");
      apply(1'b0, 1'b0, 1'b1, p_ser, "R3 gate fall");
    end

    // R4: hold while one line is high and the other toggles
    apply(1'b1, 1'b0, 1'b1, 1'b1, "R2 clock rise");
    for (int k = 0; k < 3; k++) begin
      apply(1'b1, 1'b1, 1'b1, 1'b0, "R4 gate high under clock high");
      apply(1'b1, 1'b0, 1'b1, 1'b1, "R4 gate low under clock high");
    end
    apply(1'b1, 1'b1, 1'b1, 1'b0, "R4 both high");
    apply(1'b0, 1'b1, 1'b1, 1'b1, "R4 clock low under gate high");
    apply(1'b1, 1'b1, 1'b1, 1'b0, "R4 clock high under gate high");
    apply(1'b0, 1'b0, 1'b1, 1'b0, "R4 both low");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int unsigned r;
      r = $urandom % 10;
      case (r)
        0: apply(p_clk, p_gate, 1'b0, p_ser, "R1 random load");
        1: begin
          if (!p_mode) begin
            par_a = STAGES'($urandom); par_b = STAGES'($urandom);
          end
          apply(p_clk, p_gate, p_mode, p_ser, "R1 random word");
        end
        2, 3: apply(p_clk, p_gate, 1'b1, p_ser, "R7 random mode high");
        4, 5, 6: apply(~p_clk, p_gate, p_mode, 1'($urandom % 2), "R2 random clock");
        7, 8: apply(p_clk, ~p_gate, p_mode, 1'($urandom % 2), "R3 random gate");
        default: apply(p_clk, p_gate, p_mode, ~p_ser, "R5 random serial");
      endcase
    end

    done = 1'b1;
    finish_run();
  end
endmodule